// File: doc/BRIEF.md
# Prioritised Interrupt Entry Controller

This block sits beside a processor core and decides which pending interrupt source gets serviced next. It also works out where the core continues. Twelve request lines are ranked in a fixed order. A global maskable enable gates every source except the trap and the non-maskable request. For the winner the block produces a one-cycle grant that carries the source index, a push-PC command and the new program counter.

Maskable external requests work in one of three entry modes, chosen by a set-mode command:
- Mode 0 takes a restart-style opcode from the data bus and derives a fixed page-zero address from it.
- Mode 1 always jumps to a fixed address.
- Mode 2 forms a table pointer from a vector-base byte (high) and the bus byte (low). It then fetches a two-byte handler address through a simple memory read port.

Internal peripheral sources also use the vector table. Two enable flip-flops hold the enable state, and a save-on-NMI rule lets a return-from-NMI command restore the pre-NMI state. The second flip-flop is a status output, so the core can copy it into a flag.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Request bit indices rank strictly by index, lowest index wins: 0 trap, 1 NMI, 2 external mode-0, 3 external mode-1, 4 external mode-2, 5 timer 0, 6 timer 1, 7 DMA 0, 8 DMA 1, 9 clocked serial, 10 async serial 0, 11 async serial 1. The granted index appears on `grant_idx_o`.
- R2: While the primary enable (IFF1) is clear, only bits 0 and 1 can be granted. Any other pending request produces no grant.
- R3: `set_mode_i` with `mode_sel_i` of 0, 1 or 2 selects the active entry mode, and code 3 is ignored. Of request bits 2 to 4, only bit 2+mode is eligible. The other two are ignored. The mode after reset is 0.
- R4: Trap enters at 0x0000, NMI at 0x0066 and mode-1 at 0x0038.
- R5: A mode-0 grant enters at `bus_byte_i & 0x38`, the restart target of the opcode on the bus. The byte is sampled when the request is accepted.
- R6: A mode-2 grant forms the pointer {`vec_base_i`, `bus_byte_i`}. It reads the low byte at the pointer and the high byte at pointer+1, and enters at {high, low}. The read address stays stable while `mem_req_o` is high and `mem_ack_i` is low.
- R7: An internal source at index k (5 to 11) reads its handler the same way from pointer {`vec_base_i`, 2*k}.
- R8: Accepting an NMI copies IFF1 into IFF2 and then clears IFF1. `nmi_ret_i` restores IFF1 from IFF2.
- R9: `enable_i` sets both flip-flops, and `disable_i` or the acceptance of any maskable source (bits 2 to 11) clears both. IFF2 is visible on `iff2_o`.
- R10: The grant is a single-cycle pulse on `grant_valid_o` and `push_pc_o`, one clock after acceptance for direct entries. Reset leaves no grant, no memory request and both flip-flops clear.
- R11: Accepting a trap leaves both enable flip-flops unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 12 | Pending request levels, bit 0 highest priority |
| bus_byte_i | input | 8 | Byte supplied by the interrupting device |
| vec_base_i | input | 8 | Vector-base register, upper pointer byte |
| set_mode_i | input | 1 | Strobe: load entry mode from `mode_sel_i` |
| mode_sel_i | input | 2 | Entry mode code 0, 1 or 2 |
| enable_i | input | 1 | Strobe: enable maskable interrupts |
| disable_i | input | 1 | Strobe: disable maskable interrupts |
| nmi_ret_i | input | 1 | Strobe: return from NMI, restore IFF1 |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 16 | Table read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_data_i | input | 8 | Read data byte |
| grant_valid_o | output | 1 | One-cycle grant pulse |
| grant_idx_o | output | 4 | Index of the granted source |
| push_pc_o | output | 1 | Command to the core to push its PC |
| new_pc_o | output | 16 | Handler entry address |
| iff2_o | output | 1 | Saved enable flip-flop status |

## Verification
Priority is tried with stacked request patterns: the trap with the NMI, the NMI alone, and a lowest-index-first sweep over the internal sources. Each pattern shows whether the ranking and the per-source table pointer are right. Each entry mode is run with requests on the matching and on the non-matching external lines, which shows whether mode selection really masks. Two mode-0 bus bytes show whether only the restart field is used. A mode-2 pointer with distinct high and low table bytes exposes byte-order swaps. Nested NMIs followed by a return check the save and restore between the two flip-flops, because the second NMI overwrites the saved copy with a cleared IFF1.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int BYTE_W   = 8;
  localparam int PC_W     = 2 * BYTE_W;
  localparam int SRC_N    = 12;
  localparam int IX_TRAP  = 0;
  localparam int IX_NMI   = 1;
  localparam int IX_EXT0  = 2;
  localparam int IX_EXT1  = 3;
  localparam int IX_EXT2  = 4;
  localparam logic [PC_W-1:0] TRAP_PC = 16'h0000;
  localparam logic [PC_W-1:0] NMI_PC  = 16'h0066;
  localparam logic [PC_W-1:0] EXT1_PC = 16'h0038;

  typedef enum logic [1:0] {ST_IDLE, ST_RD_LO, ST_RD_HI, ST_GRANT} entry_state_t;

  // restart opcode to page-zero target
  function automatic logic [PC_W-1:0] restart_target(input logic [BYTE_W-1:0] op);
    return {{BYTE_W{1'b0}}, op & 8'h38};
  endfunction

  // table pointer from base byte and low byte
  function automatic logic [PC_W-1:0] table_ptr(input logic [BYTE_W-1:0] base,
                                                input logic [BYTE_W-1:0] low);
    return {base, low};
  endfunction

  // low pointer byte for an internal source
  function automatic logic [BYTE_W-1:0] internal_low(input logic [3:0] idx);
    return {3'b000, idx, 1'b0};
  endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int SRC_N = 12,
  parameter int IDX_W = 4
) (
  input  logic [SRC_N-1:0] req_i,
  input  logic             iff1_i,
  input  logic [1:0]       mode_i,
  output logic             pick_valid_o,
  output logic [IDX_W-1:0] pick_idx_o
);
  import irq_vec_pkg::*;

  logic [SRC_N-1:0] eligible;

  for (genvar g = 0; g < SRC_N; g++) begin : g_elig
    if (g == IX_TRAP || g == IX_NMI) begin : g_nomask
      assign eligible[g] = req_i[g];
    end else if (g >= IX_EXT0 && g <= IX_EXT2) begin : g_ext
      assign eligible[g] = req_i[g] && iff1_i && (mode_i == 2'(g - IX_EXT0));
    end else begin : g_int
      assign eligible[g] = req_i[g] && iff1_i;
    end
  end

  always_comb begin
    pick_valid_o = 1'b0;
    pick_idx_o   = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        pick_valid_o = 1'b1;
        pick_idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_mode_i,
  input  logic [1:0] mode_sel_i,
  input  logic       enable_i,
  input  logic       disable_i,
  input  logic       nmi_ret_i,
  input  logic       acc_nmi_i,
  input  logic       acc_mask_i,
  output logic       iff1_o,
  output logic       iff2_o,
  output logic [1:0] mode_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1_o <= 1'b0;
      iff2_o <= 1'b0;
    end else if (acc_nmi_i) begin
      iff2_o <= iff1_o;
      iff1_o <= 1'b0;
    end else if (acc_mask_i || disable_i) begin
      iff1_o <= 1'b0;
      iff2_o <= 1'b0;
    end else if (enable_i) begin
      iff1_o <= 1'b1;
      iff2_o <= 1'b1;
    end else if (nmi_ret_i) begin
      iff1_o <= iff2_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_o <= 2'd0;
    else if (set_mode_i && mode_sel_i != 2'd3) mode_o <= mode_sel_i;
  end

  AST_NMI_SAVES_IFF1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_nmi_i |=> (!iff1_o && iff2_o == $past(iff1_o))); // R8
  AST_MASK_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mask_i && !acc_nmi_i) |=> (!iff1_o && !iff2_o)); // R9
  AST_RETN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ret_i && !acc_nmi_i && !acc_mask_i && !enable_i && !disable_i)
      |=> (iff1_o == $past(iff2_o))); // R8
  AST_MODE_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3); // R3
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm #(
  parameter int IDX_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              accept_i,
  input  logic [IDX_W-1:0]                  acc_idx_i,
  input  logic [irq_vec_pkg::BYTE_W-1:0]    bus_byte_i,
  input  logic [irq_vec_pkg::BYTE_W-1:0]    vec_base_i,
  input  logic                              mem_ack_i,
  input  logic [irq_vec_pkg::BYTE_W-1:0]    mem_data_i,
  output logic                              idle_o,
  output logic                              mem_req_o,
  output logic [irq_vec_pkg::PC_W-1:0]      mem_addr_o,
  output logic                              grant_valid_o,
  output logic [IDX_W-1:0]                  grant_idx_o,
  output logic [irq_vec_pkg::PC_W-1:0]      new_pc_o
);
  import irq_vec_pkg::*;

  entry_state_t          state_q;
  logic [PC_W-1:0]       ptr_q;
  logic [BYTE_W-1:0]     lo_q;
  logic                  is_direct;
  logic [PC_W-1:0]       direct_pc;
  logic [BYTE_W-1:0]     ptr_low;

  assign is_direct = acc_idx_i <= IDX_W'(IX_EXT1);
  assign ptr_low   = (acc_idx_i == IDX_W'(IX_EXT2)) ? bus_byte_i
                                                    : internal_low(4'(acc_idx_i));

  always_comb begin
    case (acc_idx_i)
      IDX_W'(IX_TRAP): direct_pc = TRAP_PC;
      IDX_W'(IX_NMI):  direct_pc = NMI_PC;
      IDX_W'(IX_EXT0): direct_pc = restart_target(bus_byte_i);
      default:         direct_pc = EXT1_PC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ptr_q       <= '0;
      lo_q        <= '0;
      grant_idx_o <= '0;
      new_pc_o    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_i) begin
          grant_idx_o <= acc_idx_i;
          if (is_direct) begin
            new_pc_o <= direct_pc;
            state_q  <= ST_GRANT;
          end else begin
            ptr_q   <= table_ptr(vec_base_i, ptr_low);
            state_q <= ST_RD_LO;
          end
        end
        ST_RD_LO: if (mem_ack_i) begin
          lo_q    <= mem_data_i;
          state_q <= ST_RD_HI;
        end
        ST_RD_HI: if (mem_ack_i) begin
          new_pc_o <= {mem_data_i, lo_q};
          state_q  <= ST_GRANT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o        = state_q == ST_IDLE;
  assign mem_req_o     = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign mem_addr_o    = (state_q == ST_RD_HI) ? ptr_q + PC_W'(1) : ptr_q;
  assign grant_valid_o = state_q == ST_GRANT;

  AST_TABLE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R6
  AST_GRANT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |=> !grant_valid_o); // R10
  AST_NMI_ENTRY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && grant_idx_o == IDX_W'(IX_NMI)) |-> new_pc_o == 16'h0066); // R4
  AST_DIRECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && idle_o && is_direct) |=> (grant_valid_o && !mem_req_o)); // R10
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int SRC_N  = irq_vec_pkg::SRC_N,
  parameter int BYTE_W = irq_vec_pkg::BYTE_W,
  localparam int PC_W  = 2 * BYTE_W,
  localparam int IDX_W = $clog2(SRC_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  req_i,
  input  logic [BYTE_W-1:0] bus_byte_i,
  input  logic [BYTE_W-1:0] vec_base_i,
  input  logic              set_mode_i,
  input  logic [1:0]        mode_sel_i,
  input  logic              enable_i,
  input  logic              disable_i,
  input  logic              nmi_ret_i,
  output logic              mem_req_o,
  output logic [PC_W-1:0]   mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic              grant_valid_o,
  output logic [IDX_W-1:0]  grant_idx_o,
  output logic              push_pc_o,
  output logic [PC_W-1:0]   new_pc_o,
  output logic              iff2_o
);
  import irq_vec_pkg::*;

  logic             iff1;
  logic [1:0]       mode;
  logic             pick_valid;
  logic [IDX_W-1:0] pick_idx;
  logic             fsm_idle;
  logic             accept;
  logic             acc_nmi;
  logic             acc_mask;

  irq_prio_pick #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_pick (
    .req_i(req_i), .iff1_i(iff1), .mode_i(mode),
    .pick_valid_o(pick_valid), .pick_idx_o(pick_idx)
  );

  assign accept   = pick_valid && fsm_idle;
  assign acc_nmi  = accept && pick_idx == IDX_W'(IX_NMI);
  assign acc_mask = accept && pick_idx >= IDX_W'(IX_EXT0);

  irq_enable_regs u_regs (
    .clk(clk), .rst_n(rst_n), .set_mode_i(set_mode_i), .mode_sel_i(mode_sel_i),
    .enable_i(enable_i), .disable_i(disable_i), .nmi_ret_i(nmi_ret_i),
    .acc_nmi_i(acc_nmi), .acc_mask_i(acc_mask),
    .iff1_o(iff1), .iff2_o(iff2_o), .mode_o(mode)
  );

  irq_entry_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .acc_idx_i(pick_idx),
    .bus_byte_i(bus_byte_i), .vec_base_i(vec_base_i),
    .mem_ack_i(mem_ack_i), .mem_data_i(mem_data_i),
    .idle_o(fsm_idle), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .grant_valid_o(grant_valid_o), .grant_idx_o(grant_idx_o), .new_pc_o(new_pc_o)
  );

  assign push_pc_o = grant_valid_o;

  AST_MASKED_ONLY_TRAP_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !iff1) |-> pick_idx < IDX_W'(IX_EXT0)); // R2
  AST_TRAP_KEEPS_IFF: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pick_idx == IDX_W'(IX_TRAP) && !enable_i && !disable_i && !nmi_ret_i)
      |=> $stable(iff2_o) && $stable(iff1)); // R11
  AST_EXT_MODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pick_idx >= IDX_W'(IX_EXT0) && pick_idx <= IDX_W'(IX_EXT2))
      |-> pick_idx == IDX_W'(IX_EXT0) + IDX_W'(mode)); // R3
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] req_i = '0;
  logic [7:0]  bus_byte_i = '0;
  logic [7:0]  vec_base_i = 8'h90;
  logic        set_mode_i = 1'b0;
  logic [1:0]  mode_sel_i = '0;
  logic        enable_i = 1'b0;
  logic        disable_i = 1'b0;
  logic        nmi_ret_i = 1'b0;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [7:0]  mem_data_i = '0;
  logic        grant_valid_o;
  logic [3:0]  grant_idx_o;
  logic        push_pc_o;
  logic [15:0] new_pc_o;
  logic        iff2_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_vector_ctrl u_irq_vector_ctrl (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always @(negedge clk) begin
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i  = 1'b1;
      mem_data_i = memf(mem_addr_o);
    end else begin
      mem_ack_i = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: enable_i = 1'b1;
      1: disable_i = 1'b1;
      default: nmi_ret_i = 1'b1;
    endcase
    @(negedge clk);
    enable_i = 1'b0; disable_i = 1'b0; nmi_ret_i = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); set_mode_i = 1'b1; mode_sel_i = m;
    @(negedge clk); set_mode_i = 1'b0;
  endtask

  // raise requests, expect a grant with the given index and pc
  task automatic expect_grant(input logic [11:0] r, input int idx, input int pc, input string tag);
    bit got = 1'b0;
    @(negedge clk); req_i = r;
    for (int n = 0; n < 30 && !got; n++) begin
      @(negedge clk);
      if (grant_valid_o) begin
        got = 1'b1;
        req_i = '0;
        check(grant_idx_o == 4'(idx), {tag, " idx"}, grant_idx_o, idx);
        check(new_pc_o == 16'(pc), {tag, " pc"}, new_pc_o, pc);
        check(push_pc_o, {tag, " push"}, push_pc_o, 1);
      end
    end
    req_i = '0;
    check(got, {tag, " grant seen"}, got, 1);
    @(negedge clk);
    check(!grant_valid_o, "R10 pulse width", grant_valid_o, 0);
  endtask

  task automatic expect_none(input logic [11:0] r, input string tag);
    bit seen = 1'b0;
    @(negedge clk); req_i = r;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if (grant_valid_o || mem_req_o) seen = 1'b1;
    end
    req_i = '0;
    check(!seen, tag, seen, 0);
  endtask

  task automatic t_reset;
    check(!grant_valid_o && !push_pc_o, "R10 reset grant", grant_valid_o, 0);
    check(!mem_req_o, "R10 reset mem_req", mem_req_o, 0);
    check(!iff2_o, "R10 reset iff2", iff2_o, 0);
  endtask

  task automatic t_masked;
    expect_none(12'hFFC, "R2 maskable blocked while disabled");
    expect_grant(12'h003, 0, 16'h0000, "R4 trap while disabled");
    expect_grant(12'h002, 1, 16'h0066, "R2 NMI while disabled");
  endtask

  task automatic t_mode1;
    pulse(0);
    check(iff2_o, "R9 enable sets iff2", iff2_o, 1);
    set_mode(2'd1);
    expect_grant(12'h008, 3, 16'h0038, "R4 mode1 entry");
    check(!iff2_o, "R9 maskable accept clears", iff2_o, 0);
    pulse(0);
    expect_none(12'h014, "R3 other external lines ignored in mode1");
    set_mode(2'd3);
    expect_grant(12'h01C, 3, 16'h0038, "R3 code 3 ignored");
  endtask

  task automatic t_mode0;
    set_mode(2'd0);
    pulse(0);
    bus_byte_i = 8'hEF;
    expect_grant(12'h01C, 2, 16'h0028, "R5 mode0 restart 28");
    pulse(0);
    bus_byte_i = 8'hC7;
    expect_grant(12'h004, 2, 16'h0000, "R5 mode0 restart 00");
  endtask

  task automatic t_mode2;
    logic [15:0] p;
    set_mode(2'd2);
    pulse(0);
    vec_base_i = 8'h90; bus_byte_i = 8'h34;
    p = 16'h9034;
    expect_grant(12'h01C, 4, {memf(p + 16'd1), memf(p)}, "R6 mode2 table");
    check(!iff2_o, "R9 mode2 accept clears", iff2_o, 0);
  endtask

  task automatic t_priority;
    logic [15:0] p;
    set_mode(2'd1);
    pulse(0);
    expect_grant(12'hFE8, 3, 16'h0038, "R1 ext above internal");
    vec_base_i = 8'hA1;
    for (int k = 5; k < 12; k++) begin
      pulse(0);
      p = {8'hA1, 8'(2 * k)};
      expect_grant(12'hFFF << k, k, {memf(p + 16'd1), memf(p)}, "R1 R7 internal rank");
    end
    pulse(0);
    expect_grant(12'hFFF, 0, 16'h0000, "R1 trap first");
    check(iff2_o, "R11 trap keeps iff", iff2_o, 1);
    expect_grant(12'h002, 1, 16'h0066, "R1 NMI second");
  endtask

  task automatic t_nmi;
    set_mode(2'd1);
    pulse(0);
    expect_grant(12'h002, 1, 16'h0066, "R8 first NMI");
    check(iff2_o, "R8 iff2 holds saved enable", iff2_o, 1);
    expect_none(12'h008, "R8 iff1 cleared by NMI");
    pulse(2);
    expect_grant(12'h008, 3, 16'h0038, "R8 return restores iff1");
    pulse(0);
    expect_grant(12'h002, 1, 16'h0066, "R8 nmi A");
    expect_grant(12'h002, 1, 16'h0066, "R8 nmi B");
    check(!iff2_o, "R8 nested NMI copies cleared iff1", iff2_o, 0);
    pulse(0);
    pulse(1);
    check(!iff2_o, "R9 disable clears", iff2_o, 0);
    expect_none(12'h008, "R9 disabled after disable");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked();
    t_mode1();
    t_mode0();
    t_mode2();
    t_priority();
    t_nmi();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule